// File: doc/BRIEF.md
# Reference-Clock Motor Speed Discriminator

This block measures the speed of a brushless motor from its tachometer pulse and reports, as pulse trains, how far the motor is from the speed set by a reference clock. The reference clock is divided by `NOMINAL × PRESCALE` (8192 with the defaults) to give the target tachometer period. Each tachometer period is counted in ticks of the reference clock divided by `PRESCALE`. A correct period counts exactly `NOMINAL` ticks.

Two pairs of pulse outputs feed an external charge-pump integrator. The speed pair carries a frequency error, issued on every second measured period. The phase pair carries the position of each tachometer edge relative to a free-running reference phase, once per period. A lock indicator, active low, shows when the last measured period lies within one sixteenth of the nominal count. The run input gates everything. Dropping it returns all outputs to neutral and clears the measurement history.

Top module: `fg_speed_disc`

## Requirements
- R1: The target period is `NOMINAL × PRESCALE` reference clocks. A measurement is the number of reference/`PRESCALE` ticks between two successive synchronized tachometer rising edges, so a period of exactly the target length yields a count of `NOMINAL` and no speed pulse.
- R2: A count above `NOMINAL` drives `spd_up` (accelerate) and a count below drives `spd_dn` (decelerate). The two are never high together.
- R3: A speed pulse lasts `|count − NOMINAL| × PRESCALE` reference clocks. Outside pulses both speed outputs are low.
- R4: The first tachometer rising edge after start only arms the measurement. Speed pulses are issued for the 1st, 3rd, 5th … measurement and never for the 2nd, 4th ….
- R5: A count of `2 × NOMINAL` or more is an overflow. It gives an `spd_up` pulse of `NOMINAL × PRESCALE` clocks and is never locked.
- R6: A phase counter runs from 0 to `NOMINAL × PRESCALE − 1` and wraps. It is 0 while stopped and becomes 1 on the first clock edge that samples run high. At each tachometer edge while running, its value p gives `ph_up` for p clocks if p is below half the target period, and `ph_dn` for (target − p) clocks otherwise. When p is 0 there is no pulse.
- R7: `lock_n` is low exactly when the latest measurement lies within ±`NOMINAL/16` counts of `NOMINAL` (inclusive) and did not overflow. It updates at every measurement and is high before the first one.
- R8: Pulses and lock changes caused by a tachometer rising edge appear on the third rising clock edge after `fg_in` rises. Two of those edges are the synchronizer.
- R9: While `rst` is high or `run` is low, from the next clock edge on, all four pulse outputs are low and `lock_n` is high, and tachometer edges are ignored. Restarting re-arms the measurement as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (1–10 MHz class) |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | 1 = motor running, 0 = stopped |
| fg_in | input | 1 | Squared tachometer pulse, asynchronous |
| spd_up | output | 1 | Speed error: accelerate request |
| spd_dn | output | 1 | Speed error: decelerate request |
| ph_up | output | 1 | Phase error: tachometer edge lags |
| ph_dn | output | 1 | Phase error: tachometer edge leads |
| lock_n | output | 1 | Low while speed is inside the lock window |

## Verification
The hardest cases to reach are the ends of the count range, where an overflow and a count one below it must give different widths. A further difficulty is that a speed pulse appears only for every other measurement, so a wrong parity is invisible unless off-nominal periods land on both kinds of slot. The bench shrinks the parameters so that one target period is 128 clocks. It then drives a table of tachometer periods: the nominal period, the exact lock-window edges on both sides, a period one tick short of overflow and one exactly at overflow. Each of these is placed on an issuing slot, and other off-nominal periods are placed on skipped slots. The phase expectation follows from an exact clock timestamp of every driven edge relative to the start. Directed steps follow: stop during a live pulse, tachometer activity while stopped, and a restart that must discard its first edge.

// File: rtl/fg_speed_disc_pkg.sv
package fg_speed_disc_pkg;

    // Width of any pulse length in reference clocks.
    localparam int PW_W = 24;

    typedef struct packed {
        logic            accel;  // 1 = up output, 0 = down output
        logic [PW_W-1:0] len;    // pulse length in reference clocks
    } pulse_req_t;

    // Speed error from a period count.
    function automatic pulse_req_t speed_req(input logic [PW_W-1:0] meas,
                                             input logic            ovf,
                                             input int unsigned     nominal,
                                             input int unsigned     prescale);
        pulse_req_t      r;
        logic [PW_W-1:0] dev;
        if (ovf) begin
            r.accel = 1'b1;
            dev     = PW_W'(nominal);
        end else if (meas >= PW_W'(nominal)) begin
            r.accel = 1'b1;
            dev     = meas - PW_W'(nominal);
        end else begin
            r.accel = 1'b0;
            dev     = PW_W'(nominal) - meas;
        end
        r.len = dev * PW_W'(prescale);
        return r;
    endfunction

    // Phase error from the reference phase at a tachometer edge.
    function automatic pulse_req_t phase_req(input logic [PW_W-1:0] ph,
                                             input int unsigned     tgt);
        pulse_req_t r;
        if (ph < PW_W'(tgt / 2)) begin
            r.accel = 1'b1;
            r.len   = ph;
        end else begin
            r.accel = 1'b0;
            r.len   = PW_W'(tgt) - ph;
        end
        return r;
    endfunction

endpackage

// File: rtl/fg_speed_disc_sync.sv
module fg_speed_disc_sync (
    input  logic clk,
    input  logic rst,
    input  logic fg_async,
    output logic rise
);
    // Two synchronizing stages plus one history stage for edge detect.
    logic [2:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[1:0], fg_async};
    end

    assign rise = sh[1] & ~sh[2];

    // R8: a detected edge lasts one cycle only
    p_rise_single_r8: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/fg_speed_disc_meter.sv
module fg_speed_disc_meter #(
    parameter  int NOMINAL  = 512,
    parameter  int PRESCALE = 16,
    localparam int CAP      = 2 * NOMINAL,
    localparam int CW       = $clog2(CAP + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          enable,
    input  logic          rise,
    output logic [CW-1:0] meas,
    output logic          ovf
);
    localparam int PSW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PSW-1:0] psc;
    logic [CW-1:0]  cnt, cnt_nx;
    logic           tick;

    // The count including this cycle's tick is the measurement when rise is high.
    always_comb begin
        tick   = (psc == PSW'(PRESCALE - 1));
        cnt_nx = (cnt == CW'(CAP)) ? cnt : cnt + CW'(tick);
    end

    assign meas = cnt_nx;
    assign ovf  = (cnt_nx == CW'(CAP));

    always_ff @(posedge clk) begin
        if (rst || !enable || rise) begin
            psc <= '0;
            cnt <= '0;
        end else begin
            psc <= tick ? '0 : psc + PSW'(1);
            cnt <= cnt_nx;
        end
    end

    // R5: the tick counter saturates at the overflow value
    p_cnt_cap_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(CAP));

endmodule

// File: rtl/fg_speed_disc_pulse.sv
module fg_speed_disc_pulse
    import fg_speed_disc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       load,
    input  pulse_req_t req,
    output logic       up,
    output logic       dn
);
    logic [PW_W-1:0] rem;
    logic            dir;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            rem <= '0;
            dir <= 1'b0;
        end else if (load) begin
            rem <= req.len;
            dir <= req.accel;
        end else if (rem != '0) begin
            rem <= rem - PW_W'(1);
        end
    end

    assign up = (rem != '0) &&  dir;
    assign dn = (rem != '0) && !dir;

    // R3: a non-empty request starts a pulse on the next cycle
    p_load_starts_r3: assert property (@(posedge clk) disable iff (rst)
        (load && !clear && req.len != '0) |=> (up || dn));

    // R3: a running pulse shortens by exactly one clock per cycle
    p_count_down_r3: assert property (@(posedge clk) disable iff (rst)
        (!load && !clear && rem != '0) |=> (rem == $past(rem) - PW_W'(1)));

endmodule

// File: rtl/fg_speed_disc.sv
module fg_speed_disc
    import fg_speed_disc_pkg::*;
#(
    parameter int NOMINAL  = 512,
    parameter int PRESCALE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fg_in,
    output logic spd_up,
    output logic spd_dn,
    output logic ph_up,
    output logic ph_dn,
    output logic lock_n
);
    localparam int TGT      = NOMINAL * PRESCALE;
    localparam int LOCK_WIN = NOMINAL / 16;
    localparam int CAP      = 2 * NOMINAL;
    localparam int CW       = $clog2(CAP + 1);
    localparam int RW       = $clog2(TGT);

    logic          rise;
    logic [CW-1:0] meas;
    logic          ovf;
    logic [RW-1:0] ref_ph;
    logic          armed, disc_turn, lock_q;
    logic          take, spd_load, ph_load;
    logic [CW-1:0] dev;
    logic          in_win;
    pulse_req_t    spd_rq, ph_rq;

    fg_speed_disc_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .fg_async (fg_in),
        .rise     (rise)
    );

    fg_speed_disc_meter #(
        .NOMINAL  (NOMINAL),
        .PRESCALE (PRESCALE)
    ) u_meter (
        .clk    (clk),
        .rst    (rst),
        .enable (run),
        .rise   (rise),
        .meas   (meas),
        .ovf    (ovf)
    );

    always_comb begin
        take     = run && rise && armed;
        spd_load = take && disc_turn;
        ph_load  = run && rise;
        dev      = (meas >= CW'(NOMINAL)) ? meas - CW'(NOMINAL)
                                          : CW'(NOMINAL) - meas;
        in_win   = !ovf && (dev <= CW'(LOCK_WIN));
        spd_rq   = speed_req(PW_W'(meas), ovf, NOMINAL, PRESCALE);
        ph_rq    = phase_req(PW_W'(ref_ph), TGT);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ref_ph    <= '0;
            armed     <= 1'b0;
            disc_turn <= 1'b1;
            lock_q    <= 1'b0;
        end else begin
            ref_ph <= (ref_ph == RW'(TGT - 1)) ? '0 : ref_ph + RW'(1);
            if (rise) armed <= 1'b1;
            if (take) begin
                disc_turn <= ~disc_turn;
                lock_q    <= in_win;
            end
        end
    end

    assign lock_n = ~lock_q;

    fg_speed_disc_pulse u_spd (
        .clk   (clk),
        .rst   (rst),
        .clear (!run),
        .load  (spd_load),
        .req   (spd_rq),
        .up    (spd_up),
        .dn    (spd_dn)
    );

    fg_speed_disc_pulse u_ph (
        .clk   (clk),
        .rst   (rst),
        .clear (!run),
        .load  (ph_load),
        .req   (ph_rq),
        .up    (ph_up),
        .dn    (ph_dn)
    );

    // R9: a stopped block is neutral and unlocked one clock later
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !run |=> (!spd_up && !spd_dn && !ph_up && !ph_dn && lock_n));

    // R7: the lock indicator moves only after an accepted measurement
    p_lock_on_meas_r7: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && !$stable(lock_n)) |-> $past(rise && armed));

endmodule

// File: tb/fg_speed_disc_bench.sv
module fg_speed_disc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NOM  = 64;
    localparam int PRE  = 2;
    localparam int TGT  = NOM * PRE;
    localparam int WDOG = 20000;
    localparam int NV   = 14;

    // Tachometer periods in reference clocks; window i measures PER[i-1].
    localparam int PER   [0:NV-1] = '{128, 128, 136, 138, 120, 118, 200,
                                      80, 254, 140, 256, 140, 100, 130};
    // Expected lock state (1 = locked) during window i.
    localparam int LOCKV [0:NV-1] = '{0, 1, 1, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0};

    logic clk = 1'b0;
    logic rst, run, fg_in;
    logic spd_up, spd_dn, ph_up, ph_dn, lock_n;

    int n_chk = 0;
    int n_bad = 0;
    int su, sd, pu, pd, first, d, ph, m, e_su, e_sd, e_pu, e_pd, e_first, viol;
    logic lk;
    string tg;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fg_speed_disc #(.NOMINAL(NOM), .PRESCALE(PRE)) u_fg_speed_disc (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .fg_in  (fg_in),
        .spd_up (spd_up),
        .spd_dn (spd_dn),
        .ph_up  (ph_up),
        .ph_dn  (ph_dn),
        .lock_n (lock_n)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Entered at a negedge: raise fg_in, then sample len cycles at negedges.
    task automatic do_window(input int len, output int c_su, output int c_sd,
                             output int c_pu, output int c_pd, output int c_first,
                             output logic c_lk);
        c_su = 0; c_sd = 0; c_pu = 0; c_pd = 0; c_first = -1; c_lk = 1'b1;
        fg_in = 1'b1;
        for (int k = 1; k <= len; k++) begin
            @(negedge clk);
            if (k == len / 2) fg_in = 1'b0;
            if (spd_up) c_su++;
            if (spd_dn) c_sd++;
            if (ph_up)  c_pu++;
            if (ph_dn)  c_pd++;
            if (c_first < 0 && (spd_up || spd_dn || ph_up || ph_dn)) c_first = k;
            c_lk = lock_n;
        end
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog: got %0d cycles expected fewer", WDOG);
        summary();
    end

    initial begin
        rst = 1'b1; run = 1'b1; fg_in = 1'b0;
        repeat (4) @(negedge clk);
        // R9: reset state, even with run high
        chk("R9 reset pulses", int'(spd_up | spd_dn | ph_up | ph_dn), 0);
        chk("R9 reset lock_n", int'(lock_n), 1);
        rst = 1'b0; run = 1'b0;
        @(negedge clk);
        run = 1'b1;
        repeat (5) @(negedge clk);
        d = 5;

        for (int i = 0; i < NV; i++) begin
            do_window(PER[i], su, sd, pu, pd, first, lk);
            e_su = 0; e_sd = 0;
            if (i >= 1 && (i % 2) == 1) begin
                m = PER[i-1] / PRE;
                if (m >= 2 * NOM)  e_su = NOM * PRE;
                else if (m >= NOM) e_su = (m - NOM) * PRE;
                else               e_sd = (NOM - m) * PRE;
            end
            ph   = (d + 2) % TGT;
            e_pu = (ph < TGT / 2) ? ph : 0;
            e_pd = (ph >= TGT / 2) ? TGT - ph : 0;
            e_first = (e_su + e_sd + e_pu + e_pd > 0) ? 3 : -1;
            if (i == 11)          tg = "R5 overflow";
            else if (i == 1)      tg = "R1 nominal";
            else if (i % 2 == 0)  tg = "R4 skipped slot";
            else                  tg = "R2 R3 speed";
            chk($sformatf("%s up w%0d", tg, i), su, e_su);
            chk($sformatf("%s dn w%0d", tg, i), sd, e_sd);
            chk($sformatf("R6 phase up w%0d", i), pu, e_pu);
            chk($sformatf("R6 phase dn w%0d", i), pd, e_pd);
            chk($sformatf("R7 lock w%0d", i), int'(lk), (LOCKV[i] != 0) ? 0 : 1);
            chk($sformatf("R8 latency w%0d", i), first, e_first);
            d += PER[i];
        end

        // Stop during a live phase pulse while locked
        fg_in = 1'b1;
        for (int k = 1; k <= 10; k++) @(negedge clk);
        chk("R6 phase live before stop", int'(ph_up), 1);
        chk("R7 locked at count NOMINAL+1", int'(lock_n), 0);
        run = 1'b0;
        @(negedge clk);
        chk("R9 stop pulses", int'(spd_up | spd_dn | ph_up | ph_dn), 0);
        chk("R9 stop lock_n", int'(lock_n), 1);
        fg_in = 1'b0;

        // Tachometer activity while stopped is ignored
        viol = 0;
        for (int k = 0; k < 120; k++) begin
            @(negedge clk);
            fg_in = ((k % 40) < 20);
            if (spd_up || spd_dn || ph_up || ph_dn || !lock_n) viol++;
        end
        chk("R9 ignored while stopped", viol, 0);

        // Restart: first edge only arms
        run = 1'b1;
        repeat (6) @(negedge clk);
        do_window(150, su, sd, pu, pd, first, lk);
        chk("R4 restart arm up", su, 0);
        chk("R4 restart arm dn", sd, 0);
        chk("R6 restart phase", pu, 8);
        do_window(150, su, sd, pu, pd, first, lk);
        chk("R4 restart first meas up", su, 22);
        chk("R4 restart first meas dn", sd, 0);
        chk("R6 restart phase 2", pu, 30);
        chk("R7 restart unlocked", int'(lk), 1);

        summary();
    end

endmodule